// File: doc/BRIEF.md
# Display Memory Host Access Port

This block is the path by which a host processor reaches a video processor's display memory and its small colour table. The host first loads a 16-bit access pointer by writing two bytes to the control port, low byte first. It then reads or writes single bytes through the data port. None of these data accesses happen at once. Each one is parked in a one-deep pending slot until the display fetch sequencer pulses a grant strobe. That strobe marks an external access window. The display memory lies outside the block, behind a simple address/strobe port with a same-cycle read return.

A single byte register, the read-ahead buffer, carries data both ways. A host data write loads it and queues a write. A host data read returns its current contents and queues a read, which refills it from memory once the grant arrives. When the colour-table select input is high, a serviced write goes to an internal 32-entry colour table instead of display memory. The packed 2-bit red, green and blue fields of the byte are widened to 8 bits each. A display-side index port reads the colour table out.

Top module: `vram_host_port`

## Requirements
- R1: After reset the pointer is 0, the read-ahead byte is 0, nothing is pending, the control sequence expects a low byte, and every colour-table entry reads 0.
- R2: A control write taken as a low byte only stores that byte. The following control write forms the pointer as {second byte, first byte}. The memory address output always shows the pointer's low 14 bits, so pointer 0xC005 addresses 0x0005.
- R3: Any data-port access returns the control sequence to expecting a low byte.
- R4: A data write loads the read-ahead byte from the host and makes the pending access a write. At the next grant, mem_we pulses with the buffer byte at the pointer address, and the pointer then advances by one.
- R5: A data read returns the current read-ahead byte and makes the pending access a read. At the next grant, mem_re pulses at the pointer address, the buffer takes the memory byte on that edge, and the pointer advances by one.
- R6: A grant with no pending access strobes neither memory enable and leaves the pointer unchanged.
- R7: Servicing an access clears the pending state, so a second grant with no new request performs nothing.
- R8: A new data request replaces an unserviced one. A write followed by a read before any grant yields exactly one read.
- R9: With colour select high, a serviced write stores into colour entry pointer[4:0] and raises no mem_we. Buffer bits 1:0, 3:2 and 5:4 give red, green and blue, each scaled as v*255/3. pal_rgb packs red in bits 23:16, green in 15:8 and blue in 7:0.
- R10: The pointer is 16 bits wide and wraps from 0xFFFF to 0x0000 on a serviced access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel_ctrl | input | 1 | 1 selects the control port, 0 the data port |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Current read-ahead byte |
| cram_sel | input | 1 | Route serviced writes to the colour table |
| slot_grant | input | 1 | One-cycle external access window strobe |
| mem_addr | output | 14 | Display memory address (pointer low bits) |
| mem_we | output | 1 | Display memory write enable |
| mem_wdata | output | 8 | Display memory write byte |
| mem_re | output | 1 | Display memory read enable |
| mem_rdata | input | 8 | Display memory read byte, valid in the mem_re cycle |
| pal_idx | input | 5 | Colour table read index |
| pal_rgb | output | 24 | Colour table entry at pal_idx |

## Verification
The memory strobes, address and write byte are combinational from the grant. They are due in the same cycle as the grant, so the bench samples them one nanosecond after raising it. Pointer, buffer, pending state and colour-table updates land on the first edge of a strobe. Each task therefore drops its strobe at the next falling edge and reads the outputs there, one edge after the stimulus. Pointer movement is seen only through mem_addr, and the pending kind only through which enable the next grant raises.

// File: rtl/vram_host_port.sv
module vram_host_port #(
  parameter int PTR_W  = 16,
  parameter int MEM_AW = 14,
  parameter int CRAM_N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel_ctrl,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              cram_sel,
  input  logic              slot_grant,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  input  logic [$clog2(CRAM_N)-1:0] pal_idx,
  output logic [23:0]       pal_rgb
);
  localparam int CIW = $clog2(CRAM_N);
  localparam logic [1:0] ACC_NONE = 2'd0, ACC_READ = 2'd1, ACC_WRITE = 2'd2;

  logic [1:0]       pend_q;
  logic             phase_q;
  logic [7:0]       lo_q, buf_q;
  logic [PTR_W-1:0] ptr_q;
  logic [23:0]      cram_q [CRAM_N];

  wire data_wr  = host_wr && !host_sel_ctrl;
  wire data_rd  = host_rd && !host_sel_ctrl && !host_wr;
  wire ctrl_wr  = host_wr && host_sel_ctrl;
  wire ptr_load = ctrl_wr && phase_q;
  wire svc_wr   = slot_grant && pend_q == ACC_WRITE;
  wire svc_rd   = slot_grant && pend_q == ACC_READ;
  wire service  = svc_wr || svc_rd;

  function automatic logic [7:0] widen(input logic [1:0] v);
    return {v, v, v, v};
  endfunction

  assign mem_addr   = ptr_q[MEM_AW-1:0];
  assign mem_we     = svc_wr && !cram_sel;
  assign mem_re     = svc_rd;
  assign mem_wdata  = buf_q;
  assign host_rdata = buf_q;
  assign pal_rgb    = cram_q[pal_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= ACC_NONE;
      phase_q <= 1'b0;
      lo_q    <= '0;
      buf_q   <= '0;
      ptr_q   <= '0;
    end else begin
      if (data_wr)      pend_q <= ACC_WRITE;
      else if (data_rd) pend_q <= ACC_READ;
      else if (service) pend_q <= ACC_NONE;

      if (data_wr || data_rd) phase_q <= 1'b0;
      else if (ctrl_wr)       phase_q <= ~phase_q;

      if (ctrl_wr && !phase_q) lo_q <= host_wdata;

      if (data_wr)     buf_q <= host_wdata;
      else if (svc_rd) buf_q <= mem_rdata;

      if (ptr_load)     ptr_q <= {{(PTR_W-16){1'b0}}, host_wdata, lo_q};
      else if (service) ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CRAM_N; i++) cram_q[i] <= '0;
    end else if (svc_wr && cram_sel) begin
      cram_q[ptr_q[CIW-1:0]] <= {widen(buf_q[1:0]), widen(buf_q[3:2]), widen(buf_q[5:4])};
    end
  end
endmodule

module vram_host_port_chk #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_grant,
  input logic [1:0]       pend,
  input logic [PTR_W-1:0] ptr,
  input logic             ptr_load,
  input logic             new_wr,
  input logic             new_rd,
  input logic             mem_we,
  input logic             mem_re
);
  AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re)); // R4
  AST_EN_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n) (mem_we || mem_re) |-> slot_grant); // R5
  AST_IDLE_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_grant && pend == 2'd0 && !ptr_load) |=> ptr == $past(ptr)); // R6
  AST_SERVICE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_grant && pend != 2'd0 && !ptr_load) |=> ptr == $past(ptr) + 1'b1); // R10
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_grant && !new_wr && !new_rd) |=> pend == 2'd0); // R7
  AST_WRITE_QUEUES: assert property (@(posedge clk) disable iff (!rst_n) new_wr |=> pend == 2'd2); // R4
  AST_READ_REPLACES: assert property (@(posedge clk) disable iff (!rst_n) new_rd |=> pend == 2'd1); // R8
endmodule

bind vram_host_port vram_host_port_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .slot_grant(slot_grant), .pend(pend_q), .ptr(ptr_q),
  .ptr_load(ptr_load), .new_wr(data_wr), .new_rd(data_rd), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/vram_host_port_tb_top.sv
module vram_host_port_tb_top;
  logic clk = 0, rst_n = 0;
  logic host_sel_ctrl = 0, host_wr = 0, host_rd = 0, cram_sel = 0, slot_grant = 0;
  logic [7:0] host_wdata = 0, host_rdata, mem_wdata, mem_rdata;
  logic [13:0] mem_addr;
  logic mem_we, mem_re;
  logic [4:0] pal_idx = 0;
  logic [23:0] pal_rgb;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ {mem_addr[13:8], 2'b01};

  vram_host_port dut_i (.*);

  function automatic logic [7:0] model_rd(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctrl(input logic [7:0] b);
    @(negedge clk); host_sel_ctrl = 1; host_wr = 1; host_wdata = b;
    @(negedge clk); host_wr = 0; host_sel_ctrl = 0;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    ctrl(p[7:0]); ctrl(p[15:8]);
  endtask

  task automatic dwrite(input logic [7:0] b);
    @(negedge clk); host_wr = 1; host_wdata = b;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic dread(output logic [7:0] b);
    @(negedge clk); host_rd = 1; #1 b = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic grant(output logic we, output logic re, output logic [13:0] a, output logic [7:0] wd);
    @(negedge clk); slot_grant = 1; #1 we = mem_we; re = mem_re; a = mem_addr; wd = mem_wdata;
    @(negedge clk); slot_grant = 0;
  endtask

  task automatic t_reset;
    logic we, re; logic [13:0] a; logic [7:0] wd;
    chk("R1 rdata", host_rdata, 0);
    chk("R1 addr", mem_addr, 0);
    chk("R1 cram", pal_rgb, 0);
    grant(we, re, a, wd);
    chk("R6 idle we", we, 0);
    chk("R6 idle re", re, 0);
    chk("R6 idle ptr", mem_addr, 0);
  endtask

  task automatic t_ctrl;
    ctrl(8'h34);
    chk("R2 low only", mem_addr, 0);
    ctrl(8'h12);
    chk("R2 ptr", mem_addr, 14'h1234);
    set_ptr(16'hC005);
    chk("R2 mask", mem_addr, 14'h0005);
  endtask

  task automatic t_phase;
    logic we, re; logic [13:0] a; logic [7:0] wd;
    set_ptr(16'h0000);
    ctrl(8'h77);
    dwrite(8'h11);
    ctrl(8'h20); ctrl(8'h00);
    chk("R3 phase reset", mem_addr, 14'h0020);
    grant(we, re, a, wd);
  endtask

  task automatic t_write;
    logic we, re; logic [13:0] a; logic [7:0] wd;
    set_ptr(16'h0ABC);
    dwrite(8'hC3);
    chk("R4 buffer", host_rdata, 8'hC3);
    grant(we, re, a, wd);
    chk("R4 we", we, 1);
    chk("R4 re", re, 0);
    chk("R4 addr", a, 14'h0ABC);
    chk("R4 data", wd, 8'hC3);
    chk("R4 advance", mem_addr, 14'h0ABD);
  endtask

  task automatic t_read;
    logic we, re; logic [13:0] a; logic [7:0] wd, b;
    set_ptr(16'h1234);
    dread(b);
    chk("R5 old byte", b, 8'hC3);
    grant(we, re, a, wd);
    chk("R5 re", re, 1);
    chk("R5 we", we, 0);
    chk("R5 addr", a, 14'h1234);
    chk("R5 fill", host_rdata, model_rd(14'h1234));
    chk("R5 advance", mem_addr, 14'h1235);
  endtask

  task automatic t_replace_clear;
    logic we, re; logic [13:0] a; logic [7:0] wd, b;
    set_ptr(16'h0100);
    dwrite(8'h33);
    dread(b);
    chk("R8 returns buffer", b, 8'h33);
    grant(we, re, a, wd);
    chk("R8 read only re", re, 1);
    chk("R8 read only we", we, 0);
    chk("R8 fill", host_rdata, model_rd(14'h0100));
    grant(we, re, a, wd);
    chk("R7 no re", re, 0);
    chk("R7 no we", we, 0);
    chk("R7 ptr held", mem_addr, 14'h0101);
  endtask

  task automatic t_cram;
    logic we, re; logic [13:0] a; logic [7:0] wd;
    cram_sel = 1;
    set_ptr(16'h0025);
    dwrite(8'h39);
    grant(we, re, a, wd);
    chk("R9 no mem we", we, 0);
    pal_idx = 5; #1;
    chk("R9 rgb", pal_rgb, {8'(1*255/3), 8'(2*255/3), 8'(3*255/3)});
    pal_idx = 0; #1;
    chk("R9 other entry", pal_rgb, 0);
    cram_sel = 0;
  endtask

  task automatic t_wrap;
    logic we, re; logic [13:0] a; logic [7:0] wd;
    set_ptr(16'hFFFF);
    chk("R10 masked", mem_addr, 14'h3FFF);
    dwrite(8'h5A);
    grant(we, re, a, wd);
    chk("R10 we", we, 1);
    chk("R10 wrap", mem_addr, 14'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_ctrl; t_phase; t_write; t_read; t_replace_clear; t_cram; t_wrap;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule